// File: doc/BRIEF.md
# Sensor Line Clock and Start-Pulse Generator

This block derives the shift-register clock for a contact image sensor line from a faster system clock. It also generates the periodic start pulse that launches each line scan. The sensor clock period, its high time and the line length are supplied as settings. Each setting is brought into range before use, and a flag records every value that had to be changed. The period is given in system clocks, and the line length is given in sensor clocks. The time between two start pulses, which is the integration time of the sensor, is therefore the line length multiplied by the period.

The sensor shift register captures the start pulse on a falling edge of its clock. For this reason the pulse is placed around exactly one falling edge, with about half a sensor clock before that edge and half a sensor clock after it. For downstream capture logic, the block issues a pixel-sample strobe at a programmable offset into every sensor clock. It also issues a line-start mark on the strobe of the first pixel clock that follows the loading edge.

Settings are captured when `run_en` is first seen high. They stay frozen until the generator is stopped and started again, so changing them while running has no effect.

Top module: `cis_clkgen`

## Requirements
- R1: When `run_en` is sampled high at edge e, the outputs are all low after edge e. From edge e+1, `sclk_o` repeats a pattern of P system cycles: high for H cycles, then low. P is `cfg_period` clamped to [ceil(SYS_KHZ/FMAX_KHZ), floor(SYS_KHZ/FMIN_KHZ)].
- R2: With `cfg_auto_duty` = 0, H is `cfg_high` clamped to [ceil(P/4), floor(3P/4)].
- R3: With `cfg_auto_duty` = 1, `cfg_high` is ignored. H is ceil(P/4) when P >= SYS_KHZ/FTYP_KHZ (sensor clock at or below the typical rate), and floor(P/2) otherwise.
- R4: The line length L is `cfg_line` raised to MIN_LINE when it is smaller. The start pulse and the line-start mark repeat every L*P system cycles.
- R5: `sstart_o` is high for exactly P consecutive cycles and covers exactly one falling edge of `sclk_o`: the falling edge of the second sensor clock of the line. It rises floor(P/2) cycles before the first low cycle of that clock.
- R6: `sample_o` is a one-cycle pulse S cycles after the first high cycle of every sensor clock, where S = min(`cfg_sample`, P-1).
- R7: `line_o` is high exactly on the `sample_o` pulse of the third sensor clock (index 2) of each line.
- R8: `cfg_err_o` bit 0 is set when the period was clamped. Bit 1 is set when the manual high time was clamped, and is never set in auto mode. Bit 2 is set when the line length was raised. Bit 3 is set when the sample offset was clamped. The flags are updated at the start of a run and held while running. Setting changes during a run do not alter the outputs.
- R9: Two edges after `run_en` is sampled low, all timing outputs are low. Reset clears the timing outputs and `cfg_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Start (rising) and stop (low) of line generation |
| cfg_period | input | PW (10) | Sensor clock period in system clocks |
| cfg_high | input | PW (10) | Manual high time in system clocks |
| cfg_line | input | LINE_W (16) | Sensor clocks per line |
| cfg_sample | input | PW (10) | Sample strobe offset after the rising edge |
| cfg_auto_duty | input | 1 | Select the rate-dependent duty cycle |
| sclk_o | output | 1 | Sensor shift-register clock |
| sstart_o | output | 1 | Line start pulse to the sensor |
| sample_o | output | 1 | Pixel sample strobe |
| line_o | output | 1 | First-pixel mark for capture logic |
| cfg_err_o | output | 4 | Clamp flags {sample, line, high, period} |

## Verification
The embedded properties assume the following about the inputs:
- `rst_n` is low from time zero.
- `run_en` changes only between edges.
- A stop is the only event that may cut a sensor clock or a start pulse short.

The duty-cycle, single-falling-edge and one-strobe-per-clock checks are therefore gated by the running state. They also skip the first clock after start, when the output pattern has just begun.

The stimulus changes the settings only while stopped, apart from one deliberate change in mid-run that exercises the freeze. Each run lasts at least two full lines, so the start pulse is seen both at startup and after the line index wraps.

// File: rtl/cis_clkgen_pkg.sv
package cis_clkgen_pkg;
   // clamp flag positions in the error vector
   localparam int ERR_PERIOD = 0;
   localparam int ERR_HIGH   = 1;
   localparam int ERR_LINE   = 2;
   localparam int ERR_SAMPLE = 3;
   localparam int ERR_N      = 4;

   // sensor clock index whose falling edge loads the start pulse
   localparam int LOAD_CLOCK  = 1;
   // sensor clock index that carries the first pixel
   localparam int FIRST_PIXEL = 2;

   function automatic int ceil_div(input int a, input int b);
      return (a + b - 1) / b;
   endfunction
endpackage

// File: rtl/cis_clkgen_limits.sv
module cis_clkgen_limits
   import cis_clkgen_pkg::*;
#(
   parameter int PW       = 10,
   parameter int LW       = 16,
   parameter int PMIN     = 17,
   parameter int PMAX     = 1000,
   parameter int PTHR     = 20,
   parameter int MIN_LINE = 960,
   parameter int HAS_AUTO = 1
) (
   input  logic [PW-1:0]    period_i,
   input  logic [PW-1:0]    high_i,
   input  logic [PW-1:0]    sample_i,
   input  logic [LW-1:0]    line_i,
   input  logic             auto_i,
   output logic [PW-1:0]    per_o,
   output logic [PW-1:0]    high_o,
   output logic [PW-1:0]    sample_o,
   output logic [LW-1:0]    line_o,
   output logic             sp_idx_o,
   output logic [PW-1:0]    sp_ph_o,
   output logic [ERR_N-1:0] err_o
);
   localparam logic [PW-1:0]   PMIN_V = PW'(PMIN);
   localparam logic [PW-1:0]   PMAX_V = PW'(PMAX);
   localparam logic [PW+1:0]   PTHR_V = (PW+2)'(PTHR);
   localparam logic [LW-1:0]   LMIN_V = LW'(MIN_LINE);

   logic [PW+1:0] per_x, lo_x, hi_x, req_x, high_x;
   logic [PW-1:0] per_m1, half;
   logic          auto_eff;

   // period range
   always_comb begin
      err_o[ERR_PERIOD] = 1'b0;
      per_o             = period_i;
      if (period_i < PMIN_V) begin
         per_o             = PMIN_V;
         err_o[ERR_PERIOD] = 1'b1;
      end else if (period_i > PMAX_V) begin
         per_o             = PMAX_V;
         err_o[ERR_PERIOD] = 1'b1;
      end
   end

   assign per_x = {2'b00, per_o};
   assign lo_x  = (per_x + (PW+2)'(3)) >> 2;
   assign hi_x  = ((per_x << 1) + per_x) >> 2;

   // duty policy variant
   generate
      if (HAS_AUTO != 0) begin : g_auto
         assign auto_eff = auto_i;
         always_comb begin
            if (auto_i)
               req_x = (per_x >= PTHR_V) ? lo_x : (per_x >> 1);
            else
               req_x = {2'b00, high_i};
         end
      end else begin : g_manual
         logic unused_auto;
         assign unused_auto = auto_i;
         assign auto_eff    = 1'b0;
         assign req_x       = {2'b00, high_i};
      end
   endgenerate

   // high time range
   always_comb begin
      high_x = req_x;
      if (req_x < lo_x)      high_x = lo_x;
      else if (req_x > hi_x) high_x = hi_x;
      err_o[ERR_HIGH] = !auto_eff && ((req_x < lo_x) || (req_x > hi_x));
   end
   assign high_o = high_x[PW-1:0];

   // sample offset range
   assign per_m1 = per_o - PW'(1);
   always_comb begin
      sample_o          = sample_i;
      err_o[ERR_SAMPLE] = 1'b0;
      if (sample_i > per_m1) begin
         sample_o          = per_m1;
         err_o[ERR_SAMPLE] = 1'b1;
      end
   end

   // line length floor
   always_comb begin
      line_o          = line_i;
      err_o[ERR_LINE] = 1'b0;
      if (line_i < LMIN_V) begin
         line_o          = LMIN_V;
         err_o[ERR_LINE] = 1'b1;
      end
   end

   // start pulse opens half a period before the loading falling edge
   assign half = per_o >> 1;
   always_comb begin
      if (high_o >= half) begin
         sp_idx_o = 1'b1;
         sp_ph_o  = high_o - half;
      end else begin
         sp_idx_o = 1'b0;
         sp_ph_o  = high_o + per_o - half;
      end
   end
endmodule

// File: rtl/cis_clkgen_phase.sv
module cis_clkgen_phase #(
   parameter int PW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [PW-1:0] per_i,
   input  logic [PW-1:0] high_i,
   input  logic [PW-1:0] smp_i,
   output logic [PW-1:0] ph_o,
   output logic          wrap_o,
   output logic          smp_hit_o,
   output logic          sclk_o,
   output logic          strobe_o
);
   logic [PW-1:0] ph;
   logic          sclk_q, strb_q;

   assign ph_o      = ph;
   assign wrap_o    = (ph == per_i - PW'(1));
   assign smp_hit_o = (ph == smp_i);
   assign sclk_o    = sclk_q;
   assign strobe_o  = strb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= '0;
         sclk_q <= 1'b0;
         strb_q <= 1'b0;
      end else begin
         if (!run || wrap_o) ph <= '0;
         else                ph <= ph + PW'(1);
         sclk_q <= run && (ph < high_i);
         strb_q <= run && smp_hit_o;
      end
   end

   // checker state: high run length and strobes per sensor clock
   logic [PW-1:0] hc;
   logic [1:0]    sc;
   logic          sclk_d, seen;
   logic          rose;
   assign rose = sclk_q && !sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hc <= '0; sc <= '0; sclk_d <= 1'b0; seen <= 1'b0;
      end else begin
         sclk_d <= sclk_q;
         hc     <= sclk_q ? hc + PW'(1) : '0;
         if (!run) begin
            sc <= '0; seen <= 1'b0;
         end else if (rose) begin
            sc <= {1'b0, strb_q}; seen <= 1'b1;
         end else if (strb_q && sc != 2'd3) begin
            sc <= sc + 2'd1;
         end
      end
   end

   assert_phase_in_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (ph < per_i));

   assert_duty_in_limits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sclk_q) && run) |->
         (({hc, 2'b00} >= {2'b00, per_i}) &&
          ({hc, 2'b00} <= ({1'b0, per_i, 1'b0} + {2'b00, per_i}))));

   assert_one_strobe_per_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && rose && seen) |-> (sc == 2'd1));
endmodule

// File: rtl/cis_clkgen_frame.sv
module cis_clkgen_frame
   import cis_clkgen_pkg::*;
#(
   parameter int PW = 10,
   parameter int LW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          wrap_i,
   input  logic          smp_hit_i,
   input  logic [PW-1:0] ph_i,
   input  logic [PW-1:0] per_i,
   input  logic [LW-1:0] line_i,
   input  logic          sp_idx_i,
   input  logic [PW-1:0] sp_ph_i,
   output logic          sp_o,
   output logic          line_o
);
   logic [LW-1:0] idx;
   logic [PW-1:0] sp_cnt;
   logic          sp_q, line_q, start_hit;

   assign start_hit = (idx == {{(LW-1){1'b0}}, sp_idx_i}) && (ph_i == sp_ph_i);
   assign sp_o      = sp_q;
   assign line_o    = line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx    <= '0;
         sp_cnt <= '0;
         sp_q   <= 1'b0;
         line_q <= 1'b0;
      end else begin
         if (!run)
            idx <= '0;
         else if (wrap_i)
            idx <= (idx == line_i - LW'(1)) ? '0 : idx + LW'(1);

         if (!run)               sp_cnt <= '0;
         else if (start_hit)     sp_cnt <= per_i - PW'(1);
         else if (sp_cnt != '0)  sp_cnt <= sp_cnt - PW'(1);

         sp_q   <= run && (start_hit || (sp_cnt != '0));
         line_q <= run && smp_hit_i && (idx == LW'(FIRST_PIXEL));
      end
   end

   assert_index_in_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (idx < line_i));

   assert_window_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && start_hit) |-> (sp_cnt == '0));
endmodule

// File: rtl/cis_clkgen.sv
module cis_clkgen
   import cis_clkgen_pkg::*;
#(
   parameter int SYS_KHZ       = 100000,
   parameter int FMAX_KHZ      = 6000,
   parameter int FMIN_KHZ      = 100,
   parameter int FTYP_KHZ      = 5000,
   parameter int MIN_LINE      = 960,
   parameter int LINE_W        = 16,
   parameter int HAS_AUTO_DUTY = 1,
   localparam int PMIN = (SYS_KHZ + FMAX_KHZ - 1) / FMAX_KHZ,
   localparam int PMAX = SYS_KHZ / FMIN_KHZ,
   localparam int PW   = $clog2(PMAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic [PW-1:0]     cfg_period,
   input  logic [PW-1:0]     cfg_high,
   input  logic [LINE_W-1:0] cfg_line,
   input  logic [PW-1:0]     cfg_sample,
   input  logic              cfg_auto_duty,
   output logic              sclk_o,
   output logic              sstart_o,
   output logic              sample_o,
   output logic              line_o,
   output logic [ERR_N-1:0]  cfg_err_o
);
   localparam int PTHR = SYS_KHZ / FTYP_KHZ;

   // elaboration-time parameter checks
   generate
      if (PMIN < 4) begin : g_bad_pmin
         $error("period floor below four system clocks");
      end
      if (FMIN_KHZ >= FMAX_KHZ) begin : g_bad_range
         $error("frequency range empty");
      end
      if (MIN_LINE < FIRST_PIXEL + 1 || MIN_LINE >= (1 << LINE_W)) begin : g_bad_line
         $error("line floor out of range");
      end
   endgenerate

   logic run, start;
   assign start = run_en && !run;

   logic [PW-1:0]     l_per, l_high, l_smp, l_spph;
   logic [LINE_W-1:0] l_line;
   logic              l_spidx;
   logic [ERR_N-1:0]  l_err;

   cis_clkgen_limits #(
      .PW(PW), .LW(LINE_W), .PMIN(PMIN), .PMAX(PMAX), .PTHR(PTHR),
      .MIN_LINE(MIN_LINE), .HAS_AUTO(HAS_AUTO_DUTY)
   ) u_limits (
      .period_i(cfg_period), .high_i(cfg_high), .sample_i(cfg_sample),
      .line_i(cfg_line), .auto_i(cfg_auto_duty),
      .per_o(l_per), .high_o(l_high), .sample_o(l_smp), .line_o(l_line),
      .sp_idx_o(l_spidx), .sp_ph_o(l_spph), .err_o(l_err)
   );

   // settings frozen for the whole run
   logic [PW-1:0]     per_q, high_q, smp_q, spph_q;
   logic [LINE_W-1:0] line_q;
   logic              spidx_q;
   logic [ERR_N-1:0]  err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run     <= 1'b0;
         per_q   <= PW'(PMIN);
         high_q  <= PW'(1);
         smp_q   <= '0;
         spph_q  <= '0;
         spidx_q <= 1'b0;
         line_q  <= LINE_W'(MIN_LINE);
         err_q   <= '0;
      end else begin
         run <= run_en;
         if (start) begin
            per_q   <= l_per;
            high_q  <= l_high;
            smp_q   <= l_smp;
            spph_q  <= l_spph;
            spidx_q <= l_spidx;
            line_q  <= l_line;
            err_q   <= l_err;
         end
      end
   end
   assign cfg_err_o = err_q;

   logic [PW-1:0] ph;
   logic          wrap, smp_hit;

   cis_clkgen_phase #(.PW(PW)) u_phase (
      .clk(clk), .rst_n(rst_n), .run(run),
      .per_i(per_q), .high_i(high_q), .smp_i(smp_q),
      .ph_o(ph), .wrap_o(wrap), .smp_hit_o(smp_hit),
      .sclk_o(sclk_o), .strobe_o(sample_o)
   );

   cis_clkgen_frame #(.PW(PW), .LW(LINE_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .run(run),
      .wrap_i(wrap), .smp_hit_i(smp_hit), .ph_i(ph), .per_i(per_q),
      .line_i(line_q), .sp_idx_i(spidx_q), .sp_ph_i(spph_q),
      .sp_o(sstart_o), .line_o(line_o)
   );

   // checker: falling edges of the sensor clock inside one start pulse
   logic       sclk_d;
   logic [1:0] sp_falls;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         sp_falls <= '0;
      end else begin
         sclk_d <= sclk_o;
         if (!sstart_o)
            sp_falls <= '0;
         else if (sclk_d && !sclk_o && sp_falls != 2'd3)
            sp_falls <= sp_falls + 2'd1;
      end
   end

   assert_start_one_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sstart_o) && run && $past(run)) |-> (sp_falls == 2'd1));

   assert_first_pixel_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      line_o |-> sample_o);

   assert_flags_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> $stable(cfg_err_o));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !$past(run)) |-> (!sclk_o && !sstart_o && !sample_o && !line_o));
endmodule

// File: tb/cis_clkgen_test.sv
module cis_clkgen_test;
   localparam int SYS  = 40000;
   localparam int MINL = 8;
   localparam int LW   = 8;
   localparam int PLO  = 7;    // ceil(40000/6000)
   localparam int PHI  = 400;  // 40000/100
   localparam int PTH  = 8;    // 40000/5000
   localparam int PW   = 9;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, run_en, cauto;
   logic [PW-1:0] cp, ch, cs;
   logic [LW-1:0] cl;
   logic          sclk, sp, smp, lst;
   logic [3:0]    err;

   cis_clkgen #(
      .SYS_KHZ(SYS), .FMAX_KHZ(6000), .FMIN_KHZ(100), .FTYP_KHZ(5000),
      .MIN_LINE(MINL), .LINE_W(LW), .HAS_AUTO_DUTY(1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en),
      .cfg_period(cp), .cfg_high(ch), .cfg_line(cl), .cfg_sample(cs),
      .cfg_auto_duty(cauto),
      .sclk_o(sclk), .sstart_o(sp), .sample_o(smp), .line_o(lst),
      .cfg_err_o(err)
   );

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic chk_idle(input string req);
      chk(req, "sclk idle", {31'd0, sclk}, 0);
      chk(req, "start idle", {31'd0, sp}, 0);
      chk(req, "sample idle", {31'd0, smp}, 0);
      chk(req, "line idle", {31'd0, lst}, 0);
   endtask

   task automatic run_case(input int p, input int h, input int l, input int s,
                           input bit a, input bit chg);
      int pe, lo, hi, he, le, se, ntot;
      bit e0, e1, e2, e3;
      string rq_clk, rq_sp;
      pe = (p < PLO) ? PLO : ((p > PHI) ? PHI : p);
      e0 = (p < PLO) || (p > PHI);
      lo = (pe + 3) / 4;
      hi = (3 * pe) / 4;
      if (a) begin
         he = (pe >= PTH) ? lo : pe / 2;
         e1 = 1'b0;
      end else begin
         he = (h < lo) ? lo : ((h > hi) ? hi : h);
         e1 = (h < lo) || (h > hi);
      end
      le = (l < MINL) ? MINL : l;
      e2 = (l < MINL);
      se = (s > pe - 1) ? pe - 1 : s;
      e3 = (s > pe - 1);
      rq_clk = a ? "R3" : (e1 ? "R2" : "R1");
      rq_sp  = e2 ? "R4" : "R5";

      cp = PW'(p); ch = PW'(h); cl = LW'(l); cs = PW'(s); cauto = a;
      run_en = 1'b1;
      ntot = 2 * le * pe + pe + 3;
      for (int st = 0; st <= ntot; st++) begin
         @(posedge clk);
         @(negedge clk);
         if (st == 0) begin
            chk_idle("R1");
         end else begin
            int n, ph, idx, t, ts;
            n   = st - 1;
            ph  = n % pe;
            idx = (n / pe) % le;
            t   = idx * pe + ph;
            ts  = pe + he - pe / 2;
            chk(rq_clk, "sclk", {31'd0, sclk}, (ph < he) ? 1 : 0);
            chk(rq_sp, "start", {31'd0, sp}, (t >= ts && t < ts + pe) ? 1 : 0);
            chk("R6", "sample", {31'd0, smp}, (ph == se) ? 1 : 0);
            chk("R7", "line", {31'd0, lst}, (ph == se && idx == 2) ? 1 : 0);
         end
         if (st == 2)
            chk("R8", "flags", {28'd0, err}, {28'd0, e3, e2, e1, e0});
         if (chg && st == 5) begin
            // R8: ignored while running
            cp = cp + PW'(3); ch = ch + PW'(2); cl = cl + LW'(5);
            cs = PW'(0); cauto = ~cauto;
         end
      end
      run_en = 1'b0;
      repeat (2) begin
         @(posedge clk);
         @(negedge clk);
      end
      for (int k = 0; k < 3; k++) begin
         chk_idle("R9");
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   initial begin
      rst_n = 1'b0; run_en = 1'b0; cauto = 1'b0;
      cp = '0; ch = '0; cl = '0; cs = '0;
      repeat (3) @(negedge clk);
      chk_idle("R9");
      chk("R9", "flags at reset", {28'd0, err}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_case(7, 3, 8, 0, 1'b0, 1'b0);
      run_case(3, 1, 4, 20, 1'b0, 1'b0);
      run_case(12, 9, 10, 11, 1'b0, 1'b0);
      run_case(12, 10, 9, 3, 1'b0, 1'b1);
      run_case(7, 0, 8, 2, 1'b1, 1'b0);
      run_case(9, 7, 8, 4, 1'b1, 1'b0);
      run_case(500, 100, 8, 399, 1'b0, 1'b0);

      // R2 sweep: every manual high time across several periods
      for (int p = 7; p <= 14; p++)
         for (int h = 0; h <= p; h++)
            run_case(p, h, 8, p / 2, 1'b0, 1'b0);

      // R3 sweep: rate-dependent duty across the threshold
      for (int p = 7; p <= 20; p++)
         run_case(p, p - 1, 8, 1, 1'b1, 1'b0);

      // R9: reset during a run clears flags and outputs
      cp = PW'(3); ch = PW'(1); cl = LW'(4); cs = PW'(20); cauto = 1'b0;
      run_en = 1'b1;
      repeat (20) @(negedge clk);
      chk("R8", "flags before reset", {28'd0, err}, 15);
      rst_n = 1'b0;
      @(negedge clk);
      chk_idle("R9");
      chk("R9", "flags after reset", {28'd0, err}, 0);
      run_en = 1'b0;
      rst_n  = 1'b1;
      @(negedge clk);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule